// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Strobe Sequencer

This block keeps an asynchronous DRAM refreshed. An interval timer, counted in clock cycles, produces one refresh obligation per period. The default of 3120 cycles at 200 MHz gives one row every 15.6 µs, which covers both 1024 rows in 16 ms and 4096 rows in 64 ms. A low-power part that tolerates a 128 ms period needs a longer interval: 6250 cycles for 4096 rows or 25000 cycles for 1024 rows. Obligations collect in a small saturating owed counter. The memory controller can therefore hold off refresh during short bursts of host traffic without losing any.

While refresh is owed and the sequencer is idle, the block raises a request. When the controller grants the bus, the block drives the row and column strobes itself for one refresh cycle.

- In strobe-order (CAS-before-RAS) mode, CAS falls first and the device's internal counter chooses the row.
- In row-address mode, CAS stays high and a local row counter is driven on the address pins while RAS is pulsed.

After reset, a burst of initial refreshes runs before the memory is declared ready. When the owed counter is full, an urgent flag tells the controller to put refresh ahead of host traffic.

Top module: `refresh_sequencer`

## Requirements
- R1: The interval timer expires once every INTERVAL clock edges, counted from reset release. The first expiry falls on the INTERVAL-th rising edge. Each expiry adds one to the owed count.
- R2: `refReq` is high exactly when the sequencer is idle and either an initial refresh or an owed refresh is pending. `refGrant` starts a refresh cycle only on an edge where `refReq` is high. At any other time it has no effect.
- R3: Once the initial burst is finished, each completed refresh cycle subtracts one from the owed count. An expiry and a completion on the same edge leave the count unchanged.
- R4: The owed count saturates at 2^OWED_W-1. An expiry that would exceed this value is dropped. `refUrgent` is high exactly while the count equals that maximum.
- R5: In strobe-order mode (`modeRasOnly`=0), `casN` is low through the setup phase and the active phase. `rasN` is low only in the active phase, so CAS falls before RAS. `addrEn` stays 0.
- R6: In row-address mode (`modeRasOnly`=1), `casN` stays 1 for the whole cycle. `addrEn` is 1 through the setup and active phases. `rowAddr` holds the local row count. That count advances by one after each row-address cycle and wraps from ROWS-1 to 0.
- R7: A refresh cycle starts on the edge after the grant and runs in this order: SETUP_CYC cycles of setup, ACT_CYC cycles with RAS low, then PRE_CYC cycles of precharge with both strobes high. The block is then idle for at least one cycle. `refBusy` is high for the whole refresh cycle.
- R8: After reset, `memReady` stays 0 until INIT_BURST refresh cycles have completed. These initial cycles do not reduce the owed count.
- R9: While in reset and directly after it, `rasN`=1, `casN`=1, `addrEn`=0, `refBusy`=0, `refUrgent`=0, `memReady`=0, `rowAddr`=0 and `refReq`=1.
- R10: `modeRasOnly` is sampled on the edge that accepts the grant. Changing it during a refresh cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refGrant | input | 1 | Controller hands the DRAM bus to the refresh sequencer |
| modeRasOnly | input | 1 | 0 = strobe-order refresh, 1 = row-address refresh |
| refReq | output | 1 | Refresh pending and sequencer idle |
| refBusy | output | 1 | Refresh cycle in progress; the block owns the strobes |
| refUrgent | output | 1 | Owed count at its maximum |
| memReady | output | 1 | Initial refresh burst complete |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| addrEn | output | 1 | Drive `rowAddr` onto the DRAM address pins |
| rowAddr | output | ROW_W | Row address for row-address refresh |

## Verification
Every output comes from registers. A grant seen on one edge therefore shows on the strobes right after the next edge. A timer expiry or a cycle completion shows in `refReq`, `refUrgent` and `memReady` right after the edge on which it occurs. The bench drives inputs and compares every output at the falling edge. Its reference model is updated on the rising edge in the same order, so each comparison looks at state that one edge has fully settled. The stimulus covers three things: grant held off until the owed count saturates, mode changes in the middle of a cycle, and enough row-address cycles to wrap the row counter.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef struct packed {
    logic busy;       // sequencer owns the strobes
    logic cycleDone;  // last precharge cycle of a refresh
    logic modeRo;     // mode latched at grant
  } seq_strobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_PRE   = 2'd3
  } seq_phase_t;
endpackage

// File: rtl/refresh_dpath.sv
module refresh_dpath
  import refresh_pkg::*;
#(
  parameter int INTERVAL   = 3120,
  parameter int OWED_W     = 3,
  parameter int INIT_BURST = 8,
  parameter int ROWS       = 1024,
  localparam int ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      stb,
  output logic             refReq,
  output logic             refUrgent,
  output logic             memReady,
  output logic [ROW_W-1:0] rowAddr
);
  localparam int TMR_W  = $clog2(INTERVAL);
  localparam int INIT_W = $clog2(INIT_BURST + 1);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;
  localparam logic [TMR_W-1:0]  TMR_LOAD = TMR_W'(INTERVAL - 1);
  localparam logic [INIT_W-1:0] INIT_LOAD = INIT_W'(INIT_BURST);

  logic [TMR_W-1:0]  tmr;
  logic [OWED_W-1:0] owed;
  logic [INIT_W-1:0] initLeft;
  logic [ROW_W-1:0]  rowCnt;
  logic tick, initActive, dec, inc;

  assign tick       = (tmr == '0);
  assign initActive = (initLeft != '0);
  assign dec        = stb.cycleDone && !initActive;
  assign inc        = tick && ((owed != OWED_MAX) || dec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmr <= TMR_LOAD;
    else if (tick) tmr <= TMR_LOAD;
    else tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else if (inc && !dec) owed <= owed + 1'b1;
    else if (dec && !inc) owed <= owed - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initLeft <= INIT_LOAD;
    else if (stb.cycleDone && initActive) initLeft <= initLeft - 1'b1;
  end

  generate
    if ((1 << ROW_W) == ROWS) begin : g_pow2_wrap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rowCnt <= '0;
        else if (stb.cycleDone && stb.modeRo) rowCnt <= rowCnt + 1'b1;
      end
    end else begin : g_cmp_wrap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rowCnt <= '0;
        else if (stb.cycleDone && stb.modeRo)
          rowCnt <= (rowCnt == ROW_W'(ROWS - 1)) ? '0 : rowCnt + 1'b1;
      end
    end
  endgenerate

  assign refReq    = !stb.busy && (initActive || (owed != '0));
  assign refUrgent = (owed == OWED_MAX);
  assign memReady  = !initActive;
  assign rowAddr   = rowCnt;

  // R1
  owed_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick && !stb.cycleDone && (owed != OWED_MAX) |=> owed == $past(owed) + 1'b1);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(owed) == OWED_MAX) |-> (owed >= OWED_MAX - 1'b1));
  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cycleDone && stb.modeRo && (rowCnt == ROW_W'(ROWS - 1)) |=> rowCnt == '0);
  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReady) |-> $past(stb.cycleDone));
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int ACT_CYC   = 10,
  parameter int PRE_CYC   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refReq,
  input  logic        refGrant,
  input  logic        modeRasOnly,
  output seq_strobe_t stb,
  output logic        rasN,
  output logic        casN,
  output logic        addrEn
);
  localparam int MAX_A = (SETUP_CYC > ACT_CYC) ? SETUP_CYC : ACT_CYC;
  localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  seq_phase_t       phase;
  logic [CNT_W-1:0] cnt;
  logic             modeRo;
  logic             last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      modeRo <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (refReq && refGrant) begin
          phase  <= PH_SETUP;
          cnt    <= CNT_W'(SETUP_CYC - 1);
          modeRo <= modeRasOnly;
        end
        PH_SETUP: if (last) begin
          phase <= PH_ACT;
          cnt   <= CNT_W'(ACT_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_ACT: if (last) begin
          phase <= PH_PRE;
          cnt   <= CNT_W'(PRE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_PRE: if (last) phase <= PH_IDLE;
                else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign stb.busy      = (phase != PH_IDLE);
  assign stb.cycleDone = (phase == PH_PRE) && last;
  assign stb.modeRo    = modeRo;

  assign rasN   = (phase != PH_ACT);
  assign casN   = !(((phase == PH_SETUP) || (phase == PH_ACT)) && !modeRo);
  assign addrEn = ((phase == PH_SETUP) || (phase == PH_ACT)) && modeRo;

  // R5
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) && !modeRo |-> $past(!casN));
  // R6
  ro_cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy && modeRo |-> casN);
  // R2
  grant_only_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.busy && !refReq |=> !stb.busy);
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy && $past(stb.busy) |-> $stable(modeRo));
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refresh_pkg::*;
#(
  parameter int INTERVAL   = 3120,
  parameter int OWED_W     = 3,
  parameter int INIT_BURST = 8,
  parameter int ROWS       = 1024,
  parameter int SETUP_CYC  = 2,
  parameter int ACT_CYC    = 10,
  parameter int PRE_CYC    = 6,
  localparam int ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGrant,
  input  logic             modeRasOnly,
  output logic             refReq,
  output logic             refBusy,
  output logic             refUrgent,
  output logic             memReady,
  output logic             rasN,
  output logic             casN,
  output logic             addrEn,
  output logic [ROW_W-1:0] rowAddr
);
  seq_strobe_t stb;

  refresh_ctrl #(
    .SETUP_CYC(SETUP_CYC), .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refReq(refReq), .refGrant(refGrant),
    .modeRasOnly(modeRasOnly), .stb(stb), .rasN(rasN), .casN(casN),
    .addrEn(addrEn)
  );

  refresh_dpath #(
    .INTERVAL(INTERVAL), .OWED_W(OWED_W), .INIT_BURST(INIT_BURST), .ROWS(ROWS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .refReq(refReq),
    .refUrgent(refUrgent), .memReady(memReady), .rowAddr(rowAddr)
  );

  assign refBusy = stb.busy;
endmodule

// File: tb/sim_refresh_sequencer.sv
module sim_refresh_sequencer;
  localparam int INTERVAL = 40;
  localparam int OWED_W   = 3;
  localparam int INIT     = 8;
  localparam int ROWS     = 16;
  localparam int SET      = 2;
  localparam int ACT      = 10;
  localparam int PRE      = 6;
  localparam int TOT      = SET + ACT + PRE;
  localparam int OMAX     = (1 << OWED_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic modeRasOnly = 1'b0;
  logic refReq, refBusy, refUrgent, memReady, rasN, casN, addrEn;
  logic [3:0] rowAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  refresh_sequencer #(
    .INTERVAL(INTERVAL), .OWED_W(OWED_W), .INIT_BURST(INIT), .ROWS(ROWS),
    .SETUP_CYC(SET), .ACT_CYC(ACT), .PRE_CYC(PRE)
  ) u0 (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .modeRasOnly(modeRasOnly),
    .refReq(refReq), .refBusy(refBusy), .refUrgent(refUrgent),
    .memReady(memReady), .rasN(rasN), .casN(casN), .addrEn(addrEn),
    .rowAddr(rowAddr)
  );

  // Behavioural reference: elapsed edges, owed/initial counts, position in cycle
  int mTime = 0, mOwed = 0, mInit = INIT, mPos = -1, mRow = 0;
  bit mRo = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mTime = 0; mOwed = 0; mInit = INIT; mPos = -1; mRow = 0; mRo = 0;
    end else begin
      bit fin, start, tick, sub, add;
      fin   = (mPos == TOT - 1);
      start = (mPos < 0) && (mOwed > 0 || mInit > 0) && refGrant;
      mTime++;
      tick  = (mTime % INTERVAL) == 0;
      sub   = fin && (mInit == 0);
      if (fin && mInit > 0) mInit--;
      add   = tick && (mOwed < OMAX || sub);
      mOwed = mOwed + int'(add) - int'(sub);
      if (fin && mRo) mRow = (mRow + 1) % ROWS;
      if (fin) mPos = -1;
      else if (mPos >= 0) mPos++;
      else if (start) begin mPos = 0; mRo = modeRasOnly; end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit inCyc;
      inCyc = (mPos >= 0) && (mPos < SET + ACT);
      chk("R2 refReq", refReq, (mPos < 0) && (mOwed > 0 || mInit > 0));
      chk("R7 refBusy", refBusy, mPos >= 0);
      chk("R4 refUrgent", refUrgent, mOwed == OMAX);
      chk("R8 memReady", memReady, mInit == 0);
      chk("R7 rasN", rasN, !(mPos >= SET && mPos < SET + ACT));
      chk("R5 casN", casN, !(inCyc && !mRo));
      chk("R6 addrEn", addrEn, inCyc && mRo);
      chk("R6 rowAddr", rowAddr, mRow);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: reset state compared every cycle while held in reset
    cycles(4);
    rstN = 1'b1;
    // R8, R5: initial burst in strobe-order mode, grant always given
    refGrant = 1'b1;
    cycles(300);
    // R1, R4: hold off grant until owed count saturates and ticks drop
    refGrant = 1'b0;
    cycles(420);
    // R6, R3: row-address cycles drain the count and wrap the row counter
    modeRasOnly = 1'b1;
    refGrant = 1'b1;
    cycles(700);
    // R10, R2: pulsed grant with mode toggling mid-cycle
    for (int i = 0; i < 60; i++) begin
      refGrant = (i % 3) != 0;
      modeRasOnly = (i % 4) < 2;
      cycles(7);
    end
    // R2: grant idle with nothing owed, then reset again mid-run (R9)
    refGrant = 1'b0;
    cycles(30);
    rstN = 1'b0;
    cycles(3);
    rstN = 1'b1;
    refGrant = 1'b1;
    modeRasOnly = 1'b0;
    cycles(200);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule